// File: doc/BRIEF.md
# Antenna diversity acquisition controller

This controller runs preamble acquisition for a direct-sequence receiver. It counts symbols in fixed dwells and decides only when a dwell ends. In dual-antenna mode it scans the two antennas in turn. When a dwell passes detection, it spends one more dwell listening on the other antenna. It then locks onto whichever antenna showed the better quality score. In single-antenna mode it stays on antenna A1. A first detection must then be confirmed by a second passing dwell on the same antenna before lock is declared, which lowers the false-alarm rate.

Once locked, the controller freezes the antenna choice and holds the symbol-timing and carrier-frequency estimates of the winning dwell. It then counts a descrambler seed period before it raises data-valid. A drop-lock pulse from the quality monitor sends it back to scanning on A1. A programmable miss limit restarts the scan from A1 after a run of empty dwells.

States and transitions:
- ST_SCAN leads to ST_CONFIRM on a dwell that passes.
- ST_CONFIRM leads to ST_SEED when the decision yields a winner.
- ST_CONFIRM returns to ST_SCAN on a failed single-mode confirmation.
- ST_SEED leads to ST_TRACK after the seed symbols.
- Any state returns to ST_SCAN on drop-lock.

Top module: `acq_div_ctrl`

## Requirements
- R1: A dwell is 16 symbol strobes. The antenna choice and the lock decision change only in the clock cycle that takes the 16th strobe of a dwell, apart from drop-lock. No change happens after only 15 strobes.
- R2: In dual mode (dual_mode=1), scanning starts on A1 after reset or drop-lock (ant_sel=0 means A1, 1 means A2). The antenna alternates at every failing dwell.
- R3: A dwell counts as a detection only when both amp_ok and phs_ok are 1 in the cycle of its last strobe.
- R4: In dual mode, a detection switches to the other antenna for one confirmation dwell. At the end of that dwell the controller locks in all cases. The second antenna wins only if it passes and its q_score is higher. It also wins on an equal score if it is A1. Otherwise the first antenna wins. ant_sel, lock_timing and lock_freq take the winner's values.
- R5: In single mode, ant_sel stays 0. A detection is followed by a confirmation dwell on A1. If that dwell passes, the controller locks with its estimates. If it fails, the controller returns to scanning without lock.
- R6: While locked and without drop-lock, ant_sel, lock_timing and lock_freq do not change, whatever the quality inputs do.
- R7: A failing dwell leaves the controller unlocked and simply scanning on. This covers a dwell that the signal only partly overlapped.
- R8: After lock, data_valid stays 0 through 6 symbol strobes. It goes to 1 in the cycle that takes the 7th strobe.
- R9: If miss_limit=L is nonzero, the L-th consecutive failing scan dwell sends the next dwell to A1 instead of alternating. When miss_limit=0 there is no restart.
- R10: A drop-lock pulse clears locked and data_valid, sets ant_sel to A1 and restarts the dwell count, all by the next cycle.
- R11: After reset, ant_sel, locked, data_valid, lock_timing and lock_freq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| sym_stb | input | 1 | one-cycle pulse per received symbol |
| dual_mode | input | 1 | 1 = two antennas, 0 = A1 only |
| miss_limit | input | 8 | empty scan dwells before restart on A1, 0 = off |
| drop_lock | input | 1 | quality monitor lost the signal |
| amp_ok | input | 1 | dwell correlator amplitude above threshold |
| phs_ok | input | 1 | dwell phase variance within threshold |
| q_score | input | QW | relative quality of the current dwell |
| q_timing | input | TW | symbol timing estimate of the current dwell |
| q_freq | input | FW | carrier frequency estimate of the current dwell |
| ant_sel | output | 1 | antenna select, 0 = A1, 1 = A2 |
| locked | output | 1 | signal acquired (seed or tracking) |
| data_valid | output | 1 | descrambler seeded, data valid |
| lock_timing | output | TW | latched timing estimate of the winner |
| lock_freq | output | FW | latched frequency estimate of the winner |

## Verification
The assertions assume three things about the inputs:
- dual_mode only changes while the controller scans on A1.
- drop_lock is a clean one-cycle pulse.
- The quality inputs are meaningful in the cycle of a dwell's last strobe.

The bench drives every input at the falling edge. It holds the quality inputs constant across a whole dwell, changes the mode only directly after a drop-lock pulse, and gives each symbol two cycles with the strobe high in the first. The strobe and drop-lock are never high together.

// File: rtl/acq_div_pkg.sv
package acq_div_pkg;
    typedef enum logic [1:0] {
        ST_SCAN    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_SEED    = 2'd2,
        ST_TRACK   = 2'd3
    } acq_st_t;

    localparam logic ANT_A1 = 1'b0;
    localparam logic ANT_A2 = 1'b1;
endpackage

// File: rtl/acq_dwell_timer.sv
module acq_dwell_timer #(
    parameter int DWELL_SYMS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sym_stb,
    output logic dwell_end
);
    localparam int CW = (DWELL_SYMS > 1) ? $clog2(DWELL_SYMS) : 1;
    localparam logic [CW-1:0] LAST = CW'(DWELL_SYMS - 1);

    logic [CW-1:0] cnt;

    assign dwell_end = sym_stb && !clr && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (sym_stb) begin
            cnt <= dwell_end ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/acq_seed_timer.sv
module acq_seed_timer #(
    parameter int SEED_SYMS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sym_stb,
    output logic done
);
    localparam int CW = (SEED_SYMS > 1) ? $clog2(SEED_SYMS) : 1;
    localparam logic [CW-1:0] LAST = CW'(SEED_SYMS - 1);

    logic [CW-1:0] cnt;

    assign done = run && sym_stb && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (sym_stb && !done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/acq_judge.sv
module acq_judge
    import acq_div_pkg::*;
#(
    parameter int QW = 8,
    parameter int TW = 4,
    parameter int FW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          dual,
    input  logic          cur_ant,
    input  logic          cur_pass,
    input  logic [QW-1:0] cur_score,
    input  logic [TW-1:0] cur_timing,
    input  logic [FW-1:0] cur_freq,
    output logic          win_ok,
    output logic          win_ant,
    output logic [TW-1:0] win_timing,
    output logic [FW-1:0] win_freq
);
    logic          st_ant;
    logic [QW-1:0] st_score;
    logic [TW-1:0] st_timing;
    logic [FW-1:0] st_freq;
    logic          take_cur;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_ant    <= ANT_A1;
            st_score  <= '0;
            st_timing <= '0;
            st_freq   <= '0;
        end else if (capture) begin
            st_ant    <= cur_ant;
            st_score  <= cur_score;
            st_timing <= cur_timing;
            st_freq   <= cur_freq;
        end
    end

    always_comb begin
        if (dual) begin
            win_ok   = 1'b1;
            take_cur = cur_pass && ((cur_score > st_score) ||
                       ((cur_score == st_score) && (cur_ant == ANT_A1)));
        end else begin
            win_ok   = cur_pass;
            take_cur = 1'b1;
        end
        win_ant    = take_cur ? cur_ant    : st_ant;
        win_timing = take_cur ? cur_timing : st_timing;
        win_freq   = take_cur ? cur_freq   : st_freq;
    end
endmodule

// File: rtl/acq_div_ctrl.sv
module acq_div_ctrl
    import acq_div_pkg::*;
#(
    parameter int QW         = 8,
    parameter int TW         = 4,
    parameter int FW         = 12,
    parameter int DWELL_SYMS = 16,
    parameter int SEED_SYMS  = 7,
    parameter int MW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sym_stb,
    input  logic          dual_mode,
    input  logic [MW-1:0] miss_limit,
    input  logic          drop_lock,
    input  logic          amp_ok,
    input  logic          phs_ok,
    input  logic [QW-1:0] q_score,
    input  logic [TW-1:0] q_timing,
    input  logic [FW-1:0] q_freq,
    output logic          ant_sel,
    output logic          locked,
    output logic          data_valid,
    output logic [TW-1:0] lock_timing,
    output logic [FW-1:0] lock_freq
);
    acq_st_t       st, st_nxt;
    logic          dwell_end;
    logic          seed_done;
    logic          capture;
    logic          pass;
    logic          win_ok;
    logic          win_ant;
    logic [TW-1:0] win_timing;
    logic [FW-1:0] win_freq;
    logic [MW-1:0] miss_cnt;
    logic          timer_clr;
    logic          miss_wrap;

    assign pass      = amp_ok && phs_ok;
    assign timer_clr = drop_lock || (st == ST_SEED) || (st == ST_TRACK);
    assign miss_wrap = (miss_limit != '0) && (miss_cnt == miss_limit - 1'b1);
    assign locked     = (st == ST_SEED) || (st == ST_TRACK);
    assign data_valid = (st == ST_TRACK);

    acq_dwell_timer #(.DWELL_SYMS(DWELL_SYMS)) u_dwell (
        .clk(clk), .rst_n(rst_n), .clr(timer_clr),
        .sym_stb(sym_stb), .dwell_end(dwell_end)
    );

    acq_seed_timer #(.SEED_SYMS(SEED_SYMS)) u_seed (
        .clk(clk), .rst_n(rst_n), .run(st == ST_SEED),
        .sym_stb(sym_stb), .done(seed_done)
    );

    acq_judge #(.QW(QW), .TW(TW), .FW(FW)) u_judge (
        .clk(clk), .rst_n(rst_n), .capture(capture), .dual(dual_mode),
        .cur_ant(ant_sel), .cur_pass(pass), .cur_score(q_score),
        .cur_timing(q_timing), .cur_freq(q_freq),
        .win_ok(win_ok), .win_ant(win_ant),
        .win_timing(win_timing), .win_freq(win_freq)
    );

    // next state
    always_comb begin
        st_nxt  = st;
        capture = 1'b0;
        unique case (st)
            ST_SCAN: begin
                if (dwell_end && pass) begin
                    st_nxt  = ST_CONFIRM;
                    capture = 1'b1;
                end
            end
            ST_CONFIRM: begin
                if (dwell_end) st_nxt = win_ok ? ST_SEED : ST_SCAN;
            end
            ST_SEED: begin
                if (seed_done) st_nxt = ST_TRACK;
            end
            ST_TRACK: st_nxt = ST_TRACK;
        endcase
        if (drop_lock) begin
            st_nxt  = ST_SCAN;
            capture = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_SCAN;
        else        st <= st_nxt;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ant_sel     <= ANT_A1;
            miss_cnt    <= '0;
            lock_timing <= '0;
            lock_freq   <= '0;
        end else if (drop_lock) begin
            ant_sel  <= ANT_A1;
            miss_cnt <= '0;
        end else begin
            unique case (st)
                ST_SCAN: begin
                    if (dwell_end) begin
                        if (pass) begin
                            ant_sel  <= dual_mode ? ~ant_sel : ANT_A1;
                            miss_cnt <= '0;
                        end else if (miss_wrap) begin
                            ant_sel  <= ANT_A1;
                            miss_cnt <= '0;
                        end else begin
                            ant_sel  <= dual_mode ? ~ant_sel : ANT_A1;
                            miss_cnt <= miss_cnt + 1'b1;
                        end
                    end
                end
                ST_CONFIRM: begin
                    if (dwell_end && win_ok) begin
                        ant_sel     <= win_ant;
                        lock_timing <= win_timing;
                        lock_freq   <= win_freq;
                    end
                end
                ST_SEED, ST_TRACK: begin
                    miss_cnt <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/acq_div_ctrl_chk.sv
module acq_div_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic dual_mode,
    input logic drop_lock,
    input logic amp_ok,
    input logic phs_ok,
    input logic ant_sel,
    input logic locked,
    input logic data_valid,
    input logic dwell_end
);
    a_r1_ant_moves_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ant_sel) |-> ($past(dwell_end) || $past(drop_lock)));

    a_r1_lock_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(dwell_end));

    a_r3_single_lock_needs_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_mode && $rose(locked)) |-> $past(amp_ok && phs_ok));

    a_r5_single_stays_a1: assert property (@(posedge clk) disable iff (!rst_n)
        !dual_mode |-> (ant_sel == 1'b0));

    a_r6_frozen_while_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !drop_lock) |=> $stable(ant_sel));

    a_r8_valid_only_locked: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> locked);

    a_r10_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        drop_lock |=> (!locked && !data_valid && (ant_sel == 1'b0)));
endmodule

bind acq_div_ctrl acq_div_ctrl_chk u_chk (.*);

// File: tb/acq_div_ctrl_test.sv
module acq_div_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_stb = 1'b0;
    logic        dual_mode = 1'b1;
    logic [7:0]  miss_limit = '0;
    logic        drop_lock = 1'b0;
    logic        amp_ok = 1'b0;
    logic        phs_ok = 1'b0;
    logic [7:0]  q_score = '0;
    logic [3:0]  q_timing = '0;
    logic [11:0] q_freq = '0;
    logic        ant_sel, locked, data_valid;
    logic [3:0]  lock_timing;
    logic [11:0] lock_freq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    acq_div_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .dual_mode(dual_mode),
        .miss_limit(miss_limit), .drop_lock(drop_lock), .amp_ok(amp_ok),
        .phs_ok(phs_ok), .q_score(q_score), .q_timing(q_timing), .q_freq(q_freq),
        .ant_sel(ant_sel), .locked(locked), .data_valid(data_valid),
        .lock_timing(lock_timing), .lock_freq(lock_freq)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic syms(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sym_stb = 1'b1;
            @(negedge clk) sym_stb = 1'b0;
        end
    endtask

    task automatic dwell(input bit a, input bit p, input int s, input int t, input int f);
        @(negedge clk);
        amp_ok = a; phs_ok = p;
        q_score = 8'(s); q_timing = 4'(t); q_freq = 12'(f);
        syms(16);
    endtask

    task automatic drop();
        @(negedge clk) drop_lock = 1'b1;
        @(negedge clk) drop_lock = 1'b0;
        chk("R10 locked", locked, 0);
        chk("R10 data_valid", data_valid, 0);
        chk("R10 ant_sel", ant_sel, 0);
    endtask

    task automatic t_reset();
        chk("R11 ant_sel", ant_sel, 0);
        chk("R11 locked", locked, 0);
        chk("R11 data_valid", data_valid, 0);
        chk("R11 lock_timing", lock_timing, 0);
        chk("R11 lock_freq", lock_freq, 0);
    endtask

    task automatic t_dual_scan();
        dwell(0, 0, 0, 0, 0);
        chk("R2 A2 after miss", ant_sel, 1);
        chk("R7 still unlocked", locked, 0);
        syms(15);
        chk("R1 no change at 15", ant_sel, 1);
        syms(1);
        chk("R2 back to A1", ant_sel, 0);
    endtask

    task automatic t_both_needed();
        dwell(1, 0, 9, 1, 1);
        chk("R3 amp only", ant_sel, 1);
        dwell(0, 1, 9, 1, 1);
        chk("R3 no lock without both", locked, 0);
        chk("R3 ant", ant_sel, 0);
    endtask

    task automatic t_pick_a2();
        dwell(1, 1, 5, 3, 100);
        chk("R4 confirm on A2", ant_sel, 1);
        chk("R4 not yet locked", locked, 0);
        dwell(1, 1, 9, 6, 200);
        chk("R4 locked", locked, 1);
        chk("R4 A2 wins", ant_sel, 1);
        chk("R4 timing", lock_timing, 6);
        chk("R4 freq", lock_freq, 200);
        syms(6);
        chk("R8 not valid at 6", data_valid, 0);
        syms(1);
        chk("R8 valid at 7", data_valid, 1);
        dwell(1, 1, 50, 1, 7);
        dwell(1, 1, 60, 2, 8);
        chk("R6 ant frozen", ant_sel, 1);
        chk("R6 timing frozen", lock_timing, 6);
        chk("R6 freq frozen", lock_freq, 200);
        drop();
    endtask

    task automatic t_tie();
        dwell(1, 1, 7, 2, 11);
        dwell(1, 1, 7, 9, 22);
        chk("R4 tie locked", locked, 1);
        chk("R4 tie goes A1", ant_sel, 0);
        chk("R4 tie timing", lock_timing, 2);
        chk("R4 tie freq", lock_freq, 11);
        drop();
    endtask

    task automatic t_keep_first();
        dwell(0, 0, 0, 0, 0);
        dwell(1, 1, 3, 5, 33);
        chk("R4 confirm on A1", ant_sel, 0);
        dwell(0, 0, 90, 1, 1);
        chk("R4 locks anyway", locked, 1);
        chk("R4 first A2 kept", ant_sel, 1);
        chk("R4 first timing", lock_timing, 5);
        drop();
    endtask

    task automatic t_single();
        @(negedge clk) dual_mode = 1'b0;
        dwell(1, 1, 1, 1, 1);
        chk("R5 stays A1", ant_sel, 0);
        chk("R5 no lock on first", locked, 0);
        dwell(0, 0, 0, 0, 0);
        chk("R5 verify fail", locked, 0);
        dwell(1, 1, 1, 4, 40);
        chk("R5 detect again", locked, 0);
        dwell(1, 1, 1, 8, 80);
        chk("R5 locked", locked, 1);
        chk("R5 ant", ant_sel, 0);
        chk("R5 timing", lock_timing, 8);
        chk("R5 freq", lock_freq, 80);
        drop();
        @(negedge clk) dual_mode = 1'b1;
    endtask

    task automatic t_miss_limit();
        miss_limit = 8'd3;
        dwell(0, 0, 0, 0, 0);
        dwell(0, 0, 0, 0, 0);
        chk("R9 second miss", ant_sel, 0);
        dwell(0, 0, 0, 0, 0);
        chk("R9 restart on A1", ant_sel, 0);
        dwell(0, 0, 0, 0, 0);
        chk("R9 resumes", ant_sel, 1);
        miss_limit = 8'd0;
        dwell(0, 0, 0, 0, 0);
        dwell(0, 0, 0, 0, 0);
        chk("R9 disabled", ant_sel, 1);
        chk("R7 unlocked", locked, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dual_scan();
        t_both_needed();
        t_pick_a2();
        t_tie();
        t_keep_first();
        t_single();
        drop();
        t_miss_limit();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule